// File: doc/BRIEF.md
# Guarded-Action Incrementer Transactor

This block is a streaming stage that sits between an upstream queue and a downstream queue. It holds one private register, the step value, which is added to every word it passes on. In each cycle a fixed-priority scheduler looks at two guarded actions and runs no more than one of them. The pass action takes a nonzero head word and sends the word plus the step downstream. The control action takes a zero head word, discards it, and raises the step by one.

Both sides use a valid/ready handshake. The block consumes a word only when one of the two actions runs. The usual arrangement chains two instances through a small buffering channel. A zero word then changes the step of the first stage and never reaches the second. The starting step comes from a parameter, and the data width comes from another.

Top module: `incr_xactor`

## Requirements
- R1: `dn_valid` is 1 exactly when `up_valid` is 1, `dn_ready` is 1 and `up_data` is nonzero; the pass action has priority over the control action.
- R2: When the pass action fires, `dn_data` equals `up_data` plus the current step, modulo 2^WIDTH.
- R3: When `up_valid` is 1 and `up_data` is 0, the control action fires whatever the value of `dn_ready`: `up_ready` is 1 and `dn_valid` is 0.
- R4: After the control action has fired, the step is one greater, and the pass action in the next cycle uses the new value.
- R5: After a synchronous active-high reset, the step equals the parameter INIT_STEP (default 1) and no handshake signal is asserted while `up_valid` is 0.
- R6: `up_ready` is 1 only in cycles in which an action fires. A nonzero word that meets `dn_ready` = 0 is neither consumed nor allowed to change the step.
- R7: `fired` is 1 in exactly those cycles in which either action fires.
- R8: The step register wraps modulo 2^WIDTH when it is bumped from its largest value.
- R9: With two chained instances whose starting steps are 1 and 2, the input sequence 1,2,0,3,4,0,1,2,3,4 produces 4,5,7,8,6,7,8,9 at the far end. Both zeros are absorbed by the first stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream head word present |
| up_data | input | WIDTH | Upstream head word |
| up_ready | output | 1 | Head word consumed this cycle |
| dn_valid | output | 1 | Downstream word offered |
| dn_data | output | WIDTH | Head word plus step |
| dn_ready | input | 1 | Downstream can accept a word |
| fired | output | 1 | An action fired this cycle |

## Verification
The hardest case to reach is a zero word that arrives while the output is stalled. Priority matters only there, and the bump must go ahead without the downstream side taking part. The bench holds `dn_ready` low, presents a zero, and then reads the new step through the sum on the next forwarded word. Step wraparound cannot be reached through the ports at the default width, so a narrow instance that starts at its largest step is bumped once instead.

// File: rtl/incr_pkg.sv
package incr_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_PASS = 2'd1,
        ACT_BUMP = 2'd2
    } act_e;

    // Fixed priority: pass is tried first, bump only if pass cannot run.
    function automatic act_e pick_action(input logic have_word,
                                         input logic room_out,
                                         input logic is_zero);
        if (have_word && room_out && !is_zero) return ACT_PASS;
        else if (have_word && is_zero)         return ACT_BUMP;
        else                                   return ACT_IDLE;
    endfunction
endpackage

// File: rtl/incr_sched.sv
module incr_sched
    import incr_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             have_word,
    input  logic [WIDTH-1:0] head,
    input  logic             room_out,
    output act_e             act
);
    logic is_zero;
    assign is_zero = (head == '0);
    assign act     = pick_action(have_word, room_out, is_zero);
endmodule

// File: rtl/incr_step_reg.sv
module incr_step_reg #(
    parameter int WIDTH     = 32,
    parameter int INIT_STEP = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    input  logic             touched,
    output logic [WIDTH-1:0] step
);
    localparam logic [WIDTH-1:0] STEP_RST = WIDTH'(INIT_STEP);

    always_ff @(posedge clk) begin
        if (rst)       step <= STEP_RST;
        else if (bump) step <= step + WIDTH'(1);
    end

    assert_bump_adds_one_R4: assert property (@(posedge clk) disable iff (rst)
        bump |=> step == $past(step) + WIDTH'(1));
    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !touched |=> $stable(step));
endmodule

// File: rtl/incr_xactor.sv
module incr_xactor
    import incr_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter int INIT_STEP = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_valid,
    input  logic [WIDTH-1:0] up_data,
    output logic             up_ready,
    output logic             dn_valid,
    output logic [WIDTH-1:0] dn_data,
    input  logic             dn_ready,
    output logic             fired
);
    act_e             act;
    logic [WIDTH-1:0] step;
    logic             do_pass;
    logic             do_bump;

    incr_sched #(.WIDTH(WIDTH)) u_sched (
        .have_word (up_valid),
        .head      (up_data),
        .room_out  (dn_ready),
        .act       (act)
    );

    assign do_pass = (act == ACT_PASS);
    assign do_bump = (act == ACT_BUMP);

    incr_step_reg #(.WIDTH(WIDTH), .INIT_STEP(INIT_STEP)) u_step (
        .clk     (clk),
        .rst     (rst),
        .bump    (do_bump),
        .touched (fired),
        .step    (step)
    );

    assign dn_valid = do_pass;
    assign dn_data  = up_data + step;
    assign up_ready = do_pass | do_bump;
    assign fired    = do_pass | do_bump;

    assert_pass_guard_R1: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> (up_valid && dn_ready && up_data != '0));
    assert_zero_absorbed_R3: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_data == '0) |-> (up_ready && !dn_valid));
    assert_ready_needs_word_R6: assert property (@(posedge clk) disable iff (rst)
        up_ready |-> up_valid);
    assert_fired_needs_word_R7: assert property (@(posedge clk) disable iff (rst)
        fired |-> up_valid);
endmodule

// File: tb/incr_xactor_bench.sv
module incr_chan #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             i_valid,
    input  logic [WIDTH-1:0] i_data,
    output logic             i_ready,
    output logic             o_valid,
    output logic [WIDTH-1:0] o_data,
    input  logic             o_ready
);
    logic full;
    logic [WIDTH-1:0] hold;
    assign i_ready = !full;
    assign o_valid = full;
    assign o_data  = hold;
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            hold <= '0;
        end else if (full) begin
            if (o_ready) full <= 1'b0;
        end else if (i_valid) begin
            full <= 1'b1;
            hold <= i_data;
        end
    end
endmodule

module incr_xactor_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    // Single unit under test
    logic        u_vld = 1'b0, d_rdy = 1'b0;
    logic [31:0] u_dat = '0;
    logic        u_rdy, d_vld, fir;
    logic [31:0] d_dat;
    incr_xactor u_incr_xactor (
        .clk(clk), .rst(rst), .up_valid(u_vld), .up_data(u_dat), .up_ready(u_rdy),
        .dn_valid(d_vld), .dn_data(d_dat), .dn_ready(d_rdy), .fired(fir));

    // Narrow instance for step wraparound
    logic       w_vld = 1'b0;
    logic [3:0] w_dat = '0;
    logic       w_rdy, w_dvld, w_fir;
    logic [3:0] w_ddat;
    incr_xactor #(.WIDTH(4), .INIT_STEP(15)) u_wrap (
        .clk(clk), .rst(rst), .up_valid(w_vld), .up_data(w_dat), .up_ready(w_rdy),
        .dn_valid(w_dvld), .dn_data(w_ddat), .dn_ready(1'b1), .fired(w_fir));

    // Chain: stage A -> channel -> stage B
    logic        a_vld = 1'b0;
    logic [31:0] a_dat = '0;
    logic        a_rdy, a_ovld, a_fir, c_rdy, c_vld, b_rdy, b_vld, b_fir;
    logic [31:0] a_odat, c_dat, b_dat;
    incr_xactor #(.INIT_STEP(1)) u_stage_a (
        .clk(clk), .rst(rst), .up_valid(a_vld), .up_data(a_dat), .up_ready(a_rdy),
        .dn_valid(a_ovld), .dn_data(a_odat), .dn_ready(c_rdy), .fired(a_fir));
    incr_chan u_chan (
        .clk(clk), .rst(rst), .i_valid(a_ovld), .i_data(a_odat), .i_ready(c_rdy),
        .o_valid(c_vld), .o_data(c_dat), .o_ready(b_rdy));
    incr_xactor #(.INIT_STEP(2)) u_stage_b (
        .clk(clk), .rst(rst), .up_valid(c_vld), .up_data(c_dat), .up_ready(b_rdy),
        .dn_valid(b_vld), .dn_data(b_dat), .dn_ready(1'b1), .fired(b_fir));

    logic [31:0] got_q [$];
    int          zeros_into_b = 0;
    always_ff @(posedge clk) begin
        if (!rst && b_vld) got_q.push_back(b_dat);
        if (!rst && c_vld && b_rdy && c_dat == 0) zeros_into_b <= zeros_into_b + 1;
    end

    task automatic step_single(input logic v, input logic [31:0] d, input logic r);
        @(negedge clk);
        u_vld = v; u_dat = d; d_rdy = r;
        #1;
    endtask

    task automatic t_reset;
        step_single(1'b0, 32'd0, 1'b1);
        chk("R5 idle dn_valid", {31'd0, d_vld}, 32'd0);
        chk("R5 idle up_ready", {31'd0, u_rdy}, 32'd0);
        chk("R7 idle fired",    {31'd0, fir},   32'd0);
    endtask

    task automatic t_pass;
        step_single(1'b1, 32'd10, 1'b1);
        chk("R1 dn_valid",   {31'd0, d_vld}, 32'd1);
        chk("R5 R2 sum",     d_dat,          32'd11);
        chk("R6 up_ready",   {31'd0, u_rdy}, 32'd1);
        chk("R7 fired",      {31'd0, fir},   32'd1);
    endtask

    task automatic t_stall_then_bump;
        step_single(1'b1, 32'd10, 1'b0);
        chk("R1 stalled dn_valid", {31'd0, d_vld}, 32'd0);
        chk("R6 stalled up_ready", {31'd0, u_rdy}, 32'd0);
        chk("R7 stalled fired",    {31'd0, fir},   32'd0);
        step_single(1'b1, 32'd0, 1'b0);
        chk("R3 zero consumed",    {31'd0, u_rdy}, 32'd1);
        chk("R3 zero no output",   {31'd0, d_vld}, 32'd0);
        chk("R7 bump fired",       {31'd0, fir},   32'd1);
        step_single(1'b1, 32'd10, 1'b1);
        chk("R4 bumped step",      d_dat,          32'd12);
        step_single(1'b1, 32'hFFFF_FFFF, 1'b1);
        chk("R2 sum wraps",        d_dat,          32'd1);
        step_single(1'b1, 32'd0, 1'b1);
        chk("R3 zero with ready",  {31'd0, d_vld}, 32'd0);
        step_single(1'b0, 32'd0, 1'b1);
    endtask

    task automatic t_wrap;
        @(negedge clk); w_vld = 1'b1; w_dat = 4'd5; #1;
        chk("R8 before wrap", {28'd0, w_ddat}, 32'd4);
        @(negedge clk); w_dat = 4'd0; #1;
        chk("R8 bump fired",  {31'd0, w_fir}, 32'd1);
        @(negedge clk); w_dat = 4'd5; #1;
        chk("R8 step wrapped", {28'd0, w_ddat}, 32'd5);
        @(negedge clk); w_vld = 1'b0;
    endtask

    task automatic t_chain;
        logic [31:0] src [10] = '{1, 2, 0, 3, 4, 0, 1, 2, 3, 4};
        logic [31:0] exp [8]  = '{4, 5, 7, 8, 6, 7, 8, 9};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            a_vld = 1'b1; a_dat = src[i];
            #1;
            while (!a_rdy) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk); a_vld = 1'b0;
        repeat (10) @(negedge clk);
        chk("R9 output count", got_q.size(), 32'd8);
        for (int i = 0; i < 8; i++)
            if (i < got_q.size()) chk("R9 chained word", got_q[i], exp[i]);
        chk("R9 zeros absorbed by first stage", zeros_into_b, 32'd0);
    endtask

    logic done = 1'b0;
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_pass();
        t_stall_then_bump();
        t_wrap();
        t_chain();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule